// File: doc/BRIEF.md
# Turbo Code Puncturing Serializer

This block sits behind the two constituent convolutional encoders of a turbo encoder. Each trellis step delivers one systematic bit plus a small vector of parity bits from each encoder. The block flattens these onto a one-bit output stream in a fixed order. A programmable, periodic puncturing mask deletes selected parity positions, which sets the code rate. With the default three parity streams per encoder, the masks give rates such as 1/2, 1/3, 1/4 and 1/6.

Steps arrive over a valid/ready input. Bits leave over a valid/ready output that stalls whenever the consumer withholds ready. Steps flagged as termination (tail) steps bypass the mask, so every bit they carry is transmitted. Another flag marks the final step of a block, and it rewinds the mask phase. The mask and its period can be rewritten only while the block is idle.

Top module: `punct_mux`

## Requirements
- R1: After reset, `out_valid` is 0, `step_ready` is 1, the mask period is 1, and row 0 keeps only parity stream 0 of each encoder (rate 1/3).
- R2: The bits of an accepted step leave in this order: the systematic bit, then encoder-1 parity streams 0..NPAR-1, then encoder-2 parity streams 0..NPAR-1. Deleted positions are skipped and the order of the rest is unchanged.
- R3: The systematic bit of every step is transmitted, whatever the mask holds.
- R4: A non-tail step uses mask row p, where p is the current phase. Row p occupies `cfg_mask[p*2*NPAR +: 2*NPAR]`. Within the row, bit j < NPAR keeps encoder-1 parity j and bit NPAR+j keeps encoder-2 parity j, with 1 meaning transmit. The phase advances by one per non-tail step and wraps at the period. A written period of 0 acts as 1, and a period above MAXPER is stored as MAXPER.
- R5: After a step with `step_last` set is accepted, the phase returns to 0, so every block starts at row 0.
- R6: A tail step transmits all 1+2*NPAR of its bits and leaves the phase unchanged.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` hold. Each output handshake carries exactly one bit, and no bit is emitted beyond those R2 to R6 call for.
- R8: With `out_ready` held high and steps always offered, consecutive output bits, including those across step boundaries, come on consecutive cycles.
- R9: A configuration write takes effect only when no block is open and no bit is pending. A write at any other time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_period | input | $clog2(MAXPER+1) | Mask period in steps |
| cfg_mask | input | MAXPER*2*NPAR | Keep mask, one 2*NPAR-bit row per phase |
| step_valid | input | 1 | A trellis step is offered |
| step_ready | output | 1 | The step is taken on this edge when valid |
| step_sys | input | 1 | Systematic bit |
| step_par1 | input | NPAR | Encoder-1 parity bits |
| step_par2 | input | NPAR | Encoder-2 parity bits |
| step_tail | input | 1 | Termination step, never punctured |
| step_last | input | 1 | Final step of the block |
| out_valid | output | 1 | Output bit is valid |
| out_ready | input | 1 | Consumer takes the output bit |
| out_bit | output | 1 | Serialized coded bit |

## Verification
The assertions rely on the producer raising `step_last` on exactly one step per block, and on tail steps arriving only at the end of a block. The bench builds every block as a run of data steps followed by tail steps, with the last flag on the final one. It also writes configuration only after it has seen the output drain, except in the one test that deliberately writes mid-block. Output readiness follows fixed arithmetic patterns, so stalls land on every position within a step.

// File: rtl/punct_pkg.sv
package punct_pkg;
  localparam int DEF_NPAR   = 3;
  localparam int DEF_MAXPER = 4;
endpackage

// File: rtl/punct_cfg.sv
module punct_cfg #(
  parameter int NPAR   = 3,
  parameter int MAXPER = 4,
  localparam int RW    = 2 * NPAR,
  localparam int PW    = $clog2(MAXPER + 1),
  localparam int MW    = MAXPER * RW,
  localparam int IX    = $clog2(MAXPER)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idle,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_period,
  input  logic [MW-1:0] cfg_mask,
  input  logic          phase_adv,
  input  logic          phase_clr,
  output logic [RW-1:0] row,
  output logic [PW-1:0] phase
);
  logic [MW-1:0] mask_q;
  logic [PW-1:0] period_q;
  logic [PW-1:0] period_eff;
  logic [RW-1:0] rows [MAXPER];
  localparam logic [RW-1:0] DEF_ROW = RW'(1) | (RW'(1) << NPAR);

  generate
    for (genvar g = 0; g < MAXPER; g++) begin : g_row
      assign rows[g] = mask_q[g*RW +: RW];
    end
  endgenerate

  assign period_eff = (period_q == '0) ? PW'(1) : period_q;
  assign row        = rows[phase[IX-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= MW'(DEF_ROW);
      period_q <= PW'(1);
      phase    <= '0;
    end else begin
      if (cfg_we && idle) begin
        mask_q   <= cfg_mask;
        period_q <= (cfg_period > PW'(MAXPER)) ? PW'(MAXPER) : cfg_period;
      end
      if (phase_clr)
        phase <= '0;
      else if (phase_adv)
        phase <= (phase + PW'(1) >= period_eff) ? '0 : phase + PW'(1);
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !idle |=> ($stable(mask_q) && $stable(period_q))); // R9
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase < period_eff); // R4
  AST_PHASE_CLR: assert property (@(posedge clk) disable iff (rst)
    phase_clr |=> (phase == '0)); // R5
endmodule

// File: rtl/punct_ser.sv
module punct_ser #(
  parameter int W  = 7,
  localparam int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic [W-1:0] ld_keep,
  input  logic         out_ready,
  output logic         out_valid,
  output logic         out_bit,
  output logic         can_take,
  output logic         busy
);
  logic [W-1:0]  data_q;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  rem_after;
  logic [IW-1:0] idx;
  logic          advance;

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (rem_q[i]) idx = IW'(i);
  end

  assign advance   = !out_valid || out_ready;
  assign rem_after = (advance && rem_q != '0) ? (rem_q & ~(W'(1) << idx)) : rem_q;
  assign can_take  = (rem_after == '0);
  assign busy      = (rem_q != '0) || out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      rem_q     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (advance) begin
        out_valid <= (rem_q != '0);
        if (rem_q != '0) out_bit <= data_q[idx];
      end
      if (load) begin
        data_q <= ld_data;
        rem_q  <= ld_keep;
      end else begin
        rem_q  <= rem_after;
      end
    end
  end

  AST_SYS_LEADS: assert property (@(posedge clk) disable iff (rst)
    load |=> rem_q[0]); // R3
  AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    (rem_q != '0 && !advance) |=> $stable(rem_q)); // R7
endmodule

// File: rtl/punct_mux.sv
module punct_mux
  import punct_pkg::*;
#(
  parameter int NPAR   = DEF_NPAR,
  parameter int MAXPER = DEF_MAXPER,
  localparam int W     = 1 + 2 * NPAR,
  localparam int RW    = 2 * NPAR,
  localparam int PW    = $clog2(MAXPER + 1),
  localparam int MW    = MAXPER * RW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [PW-1:0]   cfg_period,
  input  logic [MW-1:0]   cfg_mask,
  input  logic            step_valid,
  output logic            step_ready,
  input  logic            step_sys,
  input  logic [NPAR-1:0] step_par1,
  input  logic [NPAR-1:0] step_par2,
  input  logic            step_tail,
  input  logic            step_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_bit
);
  logic          accept;
  logic          busy;
  logic          blk_open;
  logic          idle;
  logic [RW-1:0] row;
  logic [PW-1:0] phase;
  logic [W-1:0]  keep;

  assign accept = step_valid && step_ready;
  assign idle   = !busy && !blk_open;
  assign keep   = step_tail ? {W{1'b1}} : {row, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)         blk_open <= 1'b0;
    else if (accept) blk_open <= !step_last;
  end

  punct_cfg #(.NPAR(NPAR), .MAXPER(MAXPER)) i_cfg (
    .clk(clk), .rst(rst), .idle(idle), .cfg_we(cfg_we),
    .cfg_period(cfg_period), .cfg_mask(cfg_mask),
    .phase_adv(accept && !step_tail), .phase_clr(accept && step_last),
    .row(row), .phase(phase)
  );

  punct_ser #(.W(W)) i_ser (
    .clk(clk), .rst(rst), .load(accept),
    .ld_data({step_par2, step_par1, step_sys}), .ld_keep(keep),
    .out_ready(out_ready), .out_valid(out_valid), .out_bit(out_bit),
    .can_take(step_ready), .busy(busy)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R7
  AST_TAIL_PHASE: assert property (@(posedge clk) disable iff (rst)
    (accept && step_tail && !step_last) |=> $stable(phase)); // R6
endmodule

// File: tb/test_punct_mux.sv
`timescale 1ns/1ps
module test_punct_mux;
  localparam int NPAR = 3, MAXPER = 4, RW = 6, W = 7;
  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [2:0] cfg_period = 0;
  logic [23:0] cfg_mask = 0;
  logic step_valid = 0, step_ready, step_sys = 0, step_tail = 0, step_last = 0;
  logic [2:0] step_par1 = 0, step_par2 = 0;
  logic out_valid, out_ready = 0, out_bit;

  int errors = 0, checks = 0;
  bit finished = 0;
  int cur_period = 1;
  logic [23:0] cur_mask = 24'h000009;
  bit exp_q[$];
  bit got_q[$];

  always #2 clk = ~clk;

  punct_mux i_punct_mux (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_period(cfg_period), .cfg_mask(cfg_mask),
    .step_valid(step_valid), .step_ready(step_ready), .step_sys(step_sys),
    .step_par1(step_par1), .step_par2(step_par2), .step_tail(step_tail),
    .step_last(step_last), .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit gen(input int i, input int k, input int seed);
    return ((i * 13 + k * 7 + seed * 5 + i * k) % 3) == 1;
  endfunction

  task automatic apply_cfg(input int period, input logic [23:0] mask);
    @(negedge clk);
    cfg_we = 1; cfg_period = 3'(period); cfg_mask = mask;
    @(negedge clk);
    cfg_we = 0;
    cur_period = (period == 0) ? 1 : ((period > MAXPER) ? MAXPER : period);
    cur_mask = mask;
  endtask

  task automatic run_block(input int nsteps, input int ntail, input int mode,
                           input bit poke, input int seed, input string req);
    int total = nsteps + ntail;
    int ph = 0, sent = 0, cyc = 0, first_c = -1, last_c = -1, mism = 0, bad_i = -1;
    bit prev_stall = 0, prev_bit = 0, poked = 0;
    exp_q.delete(); got_q.delete();
    for (int i = 0; i < total; i++) begin
      logic [5:0] r = cur_mask[ph*RW +: RW];
      exp_q.push_back(gen(i, 0, seed));
      for (int j = 0; j < RW; j++)
        if (i >= nsteps || r[j]) exp_q.push_back(gen(i, j + 1, seed));
      if (i < nsteps) ph = (ph + 1 >= cur_period) ? 0 : ph + 1;
    end
    @(negedge clk);
    while (got_q.size() < exp_q.size()) begin
      case (mode)
        0: out_ready = 1;
        1: out_ready = ((cyc * 7) % 5) != 0;
        default: out_ready = (cyc % 3) == 0;
      endcase
      if (sent < total) begin
        step_valid = 1;
        step_sys = gen(sent, 0, seed);
        for (int j = 0; j < NPAR; j++) begin
          step_par1[j] = gen(sent, j + 1, seed);
          step_par2[j] = gen(sent, NPAR + j + 1, seed);
        end
        step_tail = (sent >= nsteps);
        step_last = (sent == total - 1);
      end else begin
        step_valid = 0; step_tail = 0; step_last = 0;
      end
      if (poke && sent == 2 && !poked) begin
        cfg_we = 1; cfg_period = 3'd1; cfg_mask = 24'hFFFFFF; poked = 1;
      end else cfg_we = 0;
      #1;
      if (prev_stall)
        check(out_valid && out_bit == prev_bit, "R7 hold under stall", int'(out_bit), int'(prev_bit));
      prev_stall = out_valid && !out_ready;
      prev_bit = out_bit;
      if (out_valid && out_ready) begin
        got_q.push_back(out_bit);
        if (first_c < 0) first_c = cyc;
        last_c = cyc;
      end
      if (step_valid && step_ready) sent++;
      @(negedge clk);
      cyc++;
    end
    cfg_we = 0; step_valid = 0; out_ready = 1;
    @(negedge clk); @(negedge clk); #1;
    check(!out_valid, {req, " R7 no extra bits"}, int'(out_valid), 0);
    for (int i = 0; i < exp_q.size(); i++)
      if (got_q[i] != exp_q[i]) begin
        mism++;
        if (bad_i < 0) bad_i = i;
      end
    check(mism == 0, {req, " stream content"}, bad_i < 0 ? 0 : int'(got_q[bad_i]),
          bad_i < 0 ? 0 : int'(exp_q[bad_i]));
    if (mode == 0)
      check(last_c - first_c + 1 == exp_q.size(), "R8 back-to-back output",
            last_c - first_c + 1, exp_q.size());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check(out_valid == 0, "R1 reset out_valid", int'(out_valid), 0);
    check(step_ready == 1, "R1 reset step_ready", int'(step_ready), 1);
    run_block(8, 3, 0, 0, 1, "R1 R2 R6 default rate 1/3");
    apply_cfg(2, 24'h000201);
    run_block(10, 2, 1, 0, 2, "R4 rate 1/2 alternating");
    apply_cfg(1, 24'h00000B);
    run_block(9, 2, 2, 0, 3, "R2 rate 1/4");
    apply_cfg(1, 24'h00001F);
    run_block(6, 1, 0, 0, 4, "R3 rate 1/6");
    apply_cfg(1, 24'h000000);
    run_block(5, 1, 1, 0, 5, "R3 all parity deleted");
    apply_cfg(4, 24'hFC8209);
    run_block(7, 2, 2, 0, 6, "R4 period 4");
    run_block(6, 1, 0, 0, 7, "R5 phase restart");
    apply_cfg(0, 24'h000201);
    run_block(6, 1, 1, 0, 8, "R4 period 0 as 1");
    apply_cfg(7, 24'hFC8209);
    run_block(9, 1, 0, 0, 13, "R4 period saturates");
    apply_cfg(2, 24'h000201);
    run_block(8, 2, 0, 1, 9, "R9 mid-block write ignored");
    run_block(5, 1, 2, 0, 10, "R9 old config kept");
    run_block(0, 3, 1, 0, 11, "R6 tail only");
    run_block(4, 0, 0, 0, 12, "R5 no tail");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule